// File: doc/BRIEF.md
# Banked 16-pin GPIO controller

This block holds the control state of sixteen general-purpose pins that are organized as two groups of eight. Software reaches it through a byte-wide configuration port that names a logical device (a bank) and a register index inside that bank, and it issues single-cycle read or write strobes. Direction, output data and polarity inversion for each group sit in one bank. The choice between open-drain and push-pull drive sits in a second bank. A separate register in the first bank switches each group on or off.

On the pin side every pin has an output value, an output enable and an input sample. The block turns the stored configuration into those drive signals combinationally. It registers the incoming pin levels once, so that a read of the data register returns a stable value. Pads, filtering and interrupt logic lie outside the block.

Top module: `gbank_top`

## Requirements
- R1: Right after reset every pin has output enable 0 and output value 0. Both groups are disabled. Every direction register reads 0xFF, and all inversion, mode, enable and data registers read 0x00.
- R2: The enable register is bank 0x07, index 0x30. Bit 0 switches group 0 on and bit 1 switches group 1 on. Bits 7:2 read back as 0.
- R3: In bank 0x07, group g has its direction register at index 0xE0+4g, its data register at 0xE1+4g and its inversion register at 0xE2+4g. In bank 0x0F, the drive-mode register of group g is at index 0xE0+g. Pin p belongs to group p/8 at bit p%8. Any other bank/index pair reads 0x00, and a write to it changes no register and no pin.
- R4: In an enabled group, a pin whose direction bit is 1 is an input and has output enable 0 and output value 0.
- R5: In an enabled group, a pin whose direction bit is 0 and whose mode bit is 0 (push-pull) has output enable 1 and output value equal to its data bit XOR its inversion bit.
- R6: In an enabled group, a pin whose direction bit is 0 and whose mode bit is 1 (open-drain) drives low (enable 1, value 0) when data XOR inversion is 0. It releases (enable 0, value 0) when that logical level is 1.
- R7: A read of a data register in an enabled group returns, for each input bit, the pin level registered on the previous clock edge XOR the inversion bit. For each output bit it returns the stored data bit.
- R8: While a group is disabled, its pins have output enable 0 and value 0 and its data register reads 0x00. Its stored registers are kept and take effect again when the group is re-enabled.
- R9: The read data output is loaded on the clock edge that samples the read strobe and holds otherwise. If a read and a write to the same register fall in the same cycle, the read returns the content from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_dev | input | 8 | Logical device (bank) number |
| cfg_idx | input | 8 | Register index inside the bank |
| cfg_wr | input | 1 | Write strobe, one cycle per access |
| cfg_rd | input | 1 | Read strobe, one cycle per access |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Sampled pin levels |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables |

## Verification
A register read and a register write can land in the same cycle. When they target the same data register, the read must return the old content while the pin drive must take the new one. The bench raises both strobes together on a group-0 data register. It checks that the read data equals the value held before the write, that the pins reflect the written value, and that a following read returns the new value. Random traffic then mixes writes, pin changes and reads to every register, and it compares each read and all sixteen pin drives against a model held in the bench.

// File: rtl/gbank_pkg.sv
package gbank_pkg;

    localparam int BYTE_W     = 8;
    localparam int MAX_GROUPS = 8;
    localparam int GSEL_W     = 3;

    localparam logic [7:0] DEV_PORT      = 8'h07;
    localparam logic [7:0] DEV_MODE      = 8'h0F;
    localparam logic [7:0] IDX_ENABLE    = 8'h30;
    localparam logic [7:0] IDX_PORT_BASE = 8'hE0;
    localparam logic [7:0] IDX_MODE_BASE = 8'hE0;
    localparam int         PORT_STRIDE   = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ENABLE,
        SEL_DIR,
        SEL_DATA,
        SEL_INV,
        SEL_MODE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [GSEL_W-1:0] grp;
    } reg_sel_t;

    typedef struct packed {
        logic en;
        logic dir;
        logic dat;
        logic inv;
        logic od;
    } pin_cfg_t;

    typedef struct packed {
        logic out;
        logic oe;
    } pin_drive_t;

    function automatic reg_sel_t decode_sel(input logic [7:0] dev,
                                            input logic [7:0] idx,
                                            input int          groups);
        reg_sel_t   s;
        logic [7:0] pbase;
        logic [7:0] mbase;
        s.kind = SEL_NONE;
        s.grp  = '0;
        if (dev == DEV_PORT && idx == IDX_ENABLE) begin
            s.kind = SEL_ENABLE;
        end
        for (int g = 0; g < MAX_GROUPS; g++) begin
            pbase = IDX_PORT_BASE + 8'(g * PORT_STRIDE);
            mbase = IDX_MODE_BASE + 8'(g);
            if (g < groups) begin
                if (dev == DEV_PORT) begin
                    if (idx == pbase) begin
                        s.kind = SEL_DIR;
                        s.grp  = GSEL_W'(g);
                    end else if (idx == pbase + 8'd1) begin
                        s.kind = SEL_DATA;
                        s.grp  = GSEL_W'(g);
                    end else if (idx == pbase + 8'd2) begin
                        s.kind = SEL_INV;
                        s.grp  = GSEL_W'(g);
                    end
                end else if (dev == DEV_MODE && idx == mbase) begin
                    s.kind = SEL_MODE;
                    s.grp  = GSEL_W'(g);
                end
            end
        end
        return s;
    endfunction

    function automatic pin_drive_t drive_pin(input pin_cfg_t c);
        pin_drive_t d;
        logic       level;
        level = c.dat ^ c.inv;
        d.out = 1'b0;
        d.oe  = 1'b0;
        if (c.en && !c.dir) begin
            if (c.od) begin
                d.oe = ~level;
            end else begin
                d.out = level;
                d.oe  = 1'b1;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/gbank_regfile.sv
module gbank_regfile
    import gbank_pkg::*;
#(
    parameter int GROUPS  = 2,
    parameter int GROUP_W = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr,
    input  logic [7:0]                      dev,
    input  logic [7:0]                      idx,
    input  logic [BYTE_W-1:0]               wdata,
    output logic [GROUPS-1:0]               en,
    output logic [GROUPS-1:0][GROUP_W-1:0]  dir,
    output logic [GROUPS-1:0][GROUP_W-1:0]  dat,
    output logic [GROUPS-1:0][GROUP_W-1:0]  inv,
    output logic [GROUPS-1:0][GROUP_W-1:0]  od
);
    localparam int GI_W = $clog2(GROUPS);

    reg_sel_t          sel;
    logic [GI_W-1:0]   gi;

    assign sel = decode_sel(dev, idx, GROUPS);
    assign gi  = sel.grp[GI_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en  <= '0;
            dir <= '1;
            dat <= '0;
            inv <= '0;
            od  <= '0;
        end else if (wr) begin
            case (sel.kind)
                SEL_ENABLE: en      <= wdata[GROUPS-1:0];
                SEL_DIR:    dir[gi] <= wdata[GROUP_W-1:0];
                SEL_DATA:   dat[gi] <= wdata[GROUP_W-1:0];
                SEL_INV:    inv[gi] <= wdata[GROUP_W-1:0];
                SEL_MODE:   od[gi]  <= wdata[GROUP_W-1:0];
                default:    ;
            endcase
        end
    end

    // R2: an enable write lands in the enable bits on the next edge
    p_enable_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr) && $past(dev) == DEV_PORT && $past(idx) == IDX_ENABLE)
            |-> en == $past(wdata[GROUPS-1:0]));

    // R1: direction comes out of reset as all inputs
    p_reset_inputs_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> dir == '1 && en == '0);

endmodule

// File: rtl/gbank_group.sv
module gbank_group
    import gbank_pkg::*;
#(
    parameter int GROUP_W = 8
) (
    input  logic               en,
    input  logic [GROUP_W-1:0] dir,
    input  logic [GROUP_W-1:0] dat,
    input  logic [GROUP_W-1:0] inv,
    input  logic [GROUP_W-1:0] od,
    input  logic [GROUP_W-1:0] pin_smp,
    output logic [GROUP_W-1:0] pin_out,
    output logic [GROUP_W-1:0] pin_oe,
    output logic [GROUP_W-1:0] data_rd
);
    for (genvar p = 0; p < GROUP_W; p++) begin : g_pin
        pin_cfg_t   cfg;
        pin_drive_t drv;

        assign cfg.en  = en;
        assign cfg.dir = dir[p];
        assign cfg.dat = dat[p];
        assign cfg.inv = inv[p];
        assign cfg.od  = od[p];
        assign drv     = drive_pin(cfg);

        assign pin_out[p] = drv.out;
        assign pin_oe[p]  = drv.oe;
        assign data_rd[p] = !en     ? 1'b0 :
                            dir[p]  ? (pin_smp[p] ^ inv[p]) :
                                      dat[p];
    end
endmodule

// File: rtl/gbank_top.sv
module gbank_top
    import gbank_pkg::*;
#(
    parameter int GROUPS  = 2,
    parameter int GROUP_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [7:0]                  cfg_dev,
    input  logic [7:0]                  cfg_idx,
    input  logic                        cfg_wr,
    input  logic                        cfg_rd,
    input  logic [BYTE_W-1:0]           cfg_wdata,
    output logic [BYTE_W-1:0]           cfg_rdata,
    input  logic [GROUPS*GROUP_W-1:0]   pin_in,
    output logic [GROUPS*GROUP_W-1:0]   pin_out,
    output logic [GROUPS*GROUP_W-1:0]   pin_oe
);
    localparam int NPINS = GROUPS * GROUP_W;
    localparam int GI_W  = $clog2(GROUPS);

    logic [GROUPS-1:0]              en_w;
    logic [GROUPS-1:0][GROUP_W-1:0] dir_w;
    logic [GROUPS-1:0][GROUP_W-1:0] dat_w;
    logic [GROUPS-1:0][GROUP_W-1:0] inv_w;
    logic [GROUPS-1:0][GROUP_W-1:0] od_w;
    logic [GROUPS-1:0][GROUP_W-1:0] rd_w;
    logic [NPINS-1:0]               smp_q;
    logic [BYTE_W-1:0]              rmux;
    reg_sel_t                       rsel;
    logic [GI_W-1:0]                rgi;

    gbank_regfile #(.GROUPS(GROUPS), .GROUP_W(GROUP_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .dev   (cfg_dev),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .en    (en_w),
        .dir   (dir_w),
        .dat   (dat_w),
        .inv   (inv_w),
        .od    (od_w)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        gbank_group #(.GROUP_W(GROUP_W)) u_group (
            .en      (en_w[g]),
            .dir     (dir_w[g]),
            .dat     (dat_w[g]),
            .inv     (inv_w[g]),
            .od      (od_w[g]),
            .pin_smp (smp_q[g*GROUP_W +: GROUP_W]),
            .pin_out (pin_out[g*GROUP_W +: GROUP_W]),
            .pin_oe  (pin_oe[g*GROUP_W +: GROUP_W]),
            .data_rd (rd_w[g])
        );

        // R8: a disabled group neither drives nor pulls its pins
        p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (rst)
            !en_w[g] |-> pin_oe[g*GROUP_W +: GROUP_W] == '0
                      && pin_out[g*GROUP_W +: GROUP_W] == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= '0;
        end else begin
            smp_q <= pin_in;
        end
    end

    assign rsel = decode_sel(cfg_dev, cfg_idx, GROUPS);
    assign rgi  = rsel.grp[GI_W-1:0];

    always_comb begin
        rmux = '0;
        case (rsel.kind)
            SEL_ENABLE: rmux[GROUPS-1:0]  = en_w;
            SEL_DIR:    rmux[GROUP_W-1:0] = dir_w[rgi];
            SEL_DATA:   rmux[GROUP_W-1:0] = rd_w[rgi];
            SEL_INV:    rmux[GROUP_W-1:0] = inv_w[rgi];
            SEL_MODE:   rmux[GROUP_W-1:0] = od_w[rgi];
            default:    rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rdata <= '0;
        end else if (cfg_rd) begin
            cfg_rdata <= rmux;
        end
    end

    // R4: an input pin never has its driver on
    p_input_released_r4: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & dir_w) == '0);

    // R6: an open-drain pin only ever drives low
    p_od_low_only_r6: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & od_w & pin_out) == '0);

    // R1: the first cycle out of reset leaves every pin released
    p_reset_tristate_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pin_oe == '0 && pin_out == '0);

    // R9: without a read strobe the read data holds
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_rd)) |-> $stable(cfg_rdata));

endmodule

// File: tb/gbank_top_bench.sv
module gbank_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_dev = '0;
    logic [7:0]  cfg_idx = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [1:0] m_en;
    logic [7:0] m_dir [2];
    logic [7:0] m_dat [2];
    logic [7:0] m_inv [2];
    logic [7:0] m_od  [2];

    always #4 clk = ~clk;

    gbank_top u_gbank_top (
        .clk(clk), .rst(rst), .cfg_dev(cfg_dev), .cfg_idx(cfg_idx),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_en = '0;
        for (int g = 0; g < 2; g++) begin
            m_dir[g] = 8'hFF; m_dat[g] = '0; m_inv[g] = '0; m_od[g] = '0;
        end
    endtask

    task automatic model_write(input logic [7:0] d, input logic [7:0] i, input logic [7:0] v);
        if (d == 8'h07) begin
            if (i == 8'h30) m_en = v[1:0];
            for (int g = 0; g < 2; g++) begin
                if (i == 8'hE0 + 8'(4*g)) m_dir[g] = v;
                if (i == 8'hE1 + 8'(4*g)) m_dat[g] = v;
                if (i == 8'hE2 + 8'(4*g)) m_inv[g] = v;
            end
        end else if (d == 8'h0F) begin
            if (i == 8'hE0) m_od[0] = v;
            if (i == 8'hE1) m_od[1] = v;
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] d, input logic [7:0] i);
        logic [7:0] r;
        r = '0;
        if (d == 8'h07) begin
            if (i == 8'h30) r = {6'b0, m_en};
            for (int g = 0; g < 2; g++) begin
                if (i == 8'hE0 + 8'(4*g)) r = m_dir[g];
                if (i == 8'hE1 + 8'(4*g))
                    r = m_en[g] ? ((m_dir[g] & (pin_in[g*8 +: 8] ^ m_inv[g])) | (~m_dir[g] & m_dat[g])) : 8'h00;
                if (i == 8'hE2 + 8'(4*g)) r = m_inv[g];
            end
        end else if (d == 8'h0F) begin
            if (i == 8'hE0) r = m_od[0];
            if (i == 8'hE1) r = m_od[1];
        end
        return r;
    endfunction

    function automatic logic [1:0] exp_drive(input int p);
        int g; int b; logic lvl;
        g = p / 8; b = p % 8;
        lvl = m_dat[g][b] ^ m_inv[g][b];
        if (!m_en[g] || m_dir[g][b]) return 2'b00;
        if (m_od[g][b]) return {1'b0, ~lvl};
        return {lvl, 1'b1};
    endfunction

    task automatic do_wr(input logic [7:0] d, input logic [7:0] i, input logic [7:0] v);
        @(negedge clk);
        cfg_dev = d; cfg_idx = i; cfg_wdata = v; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        model_write(d, i, v);
    endtask

    task automatic do_rd(input logic [7:0] d, input logic [7:0] i, output logic [7:0] v);
        @(negedge clk);
        cfg_dev = d; cfg_idx = i; cfg_rd = 1'b1;
        @(negedge clk);
        cfg_rd = 1'b0;
        v = cfg_rdata;
    endtask

    task automatic rd_chk(input logic [7:0] d, input logic [7:0] i, input string req);
        logic [7:0] e; logic [7:0] v;
        e = exp_read(d, i);
        do_rd(d, i, v);
        chk(v == e, req, v, e);
    endtask

    task automatic pins_chk(input string req);
        logic [1:0] e;
        for (int p = 0; p < 16; p++) begin
            e = exp_drive(p);
            chk({pin_out[p], pin_oe[p]} == e, req, {pin_out[p], pin_oe[p]}, e);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        pins_chk("R1 reset pins");
        rd_chk(8'h07, 8'hE0, "R1 dir0 reset");
        rd_chk(8'h07, 8'hE4, "R1 dir1 reset");
        rd_chk(8'h07, 8'h30, "R1 enable reset");
        rd_chk(8'h0F, 8'hE1, "R1 mode1 reset");

        // R2 enable bits, upper bits read zero
        do_wr(8'h07, 8'h30, 8'hFF);
        rd_chk(8'h07, 8'h30, "R2 enable readback");
        chk(m_en == 2'b11, "R2 model", m_en, 3);

        // R5 push-pull outputs with inversion
        do_wr(8'h07, 8'hE0, 8'h00);
        do_wr(8'h07, 8'hE1, 8'hC3);
        do_wr(8'h07, 8'hE2, 8'h0F);
        pins_chk("R5 push-pull group0");
        rd_chk(8'h07, 8'hE1, "R7 output data read");

        // R6 open-drain on group 1
        do_wr(8'h07, 8'hE4, 8'h00);
        do_wr(8'h07, 8'hE5, 8'h5A);
        do_wr(8'h0F, 8'hE1, 8'hFF);
        pins_chk("R6 open-drain group1");

        // R4 and R7 inputs with inversion
        do_wr(8'h07, 8'hE4, 8'hF0);
        do_wr(8'h07, 8'hE6, 8'h33);
        pin_in = 16'hA55A;
        pins_chk("R4 input release");
        rd_chk(8'h07, 8'hE5, "R7 input data read");

        // R3 unmapped addresses and wrong bank are ignored
        do_wr(8'h0F, 8'hE2, 8'h55);
        do_wr(8'h07, 8'hE3, 8'h55);
        do_wr(8'h0F, 8'h30, 8'h00);
        rd_chk(8'h07, 8'hE2, "R3 inv0 untouched");
        rd_chk(8'h07, 8'h30, "R3 enable untouched");
        rd_chk(8'h07, 8'hE3, "R3 hole reads zero");
        pins_chk("R3 pins untouched");

        // R8 disable keeps registers, re-enable restores
        do_wr(8'h07, 8'h30, 8'h01);
        pins_chk("R8 group1 quiet");
        rd_chk(8'h07, 8'hE5, "R8 disabled data zero");
        rd_chk(8'h07, 8'hE4, "R8 dir kept");
        do_wr(8'h07, 8'h30, 8'h03);
        pins_chk("R8 re-enabled");

        // R9 same-cycle read and write of data register
        do_wr(8'h07, 8'hE2, 8'h00);
        do_wr(8'h07, 8'hE1, 8'h0F);
        @(negedge clk);
        cfg_dev = 8'h07; cfg_idx = 8'hE1; cfg_wdata = 8'hA5; cfg_wr = 1'b1; cfg_rd = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_rd = 1'b0;
        chk(cfg_rdata == 8'h0F, "R9 read-before-write", cfg_rdata, 8'h0F);
        model_write(8'h07, 8'hE1, 8'hA5);
        pins_chk("R9 write took effect");
        rd_chk(8'h07, 8'hE1, "R9 new value");
        repeat (3) @(negedge clk);
        chk(cfg_rdata == 8'hA5, "R9 rdata hold", cfg_rdata, 8'hA5);

        // random traffic R2-R8
        for (int n = 0; n < 400; n++) begin
            logic [7:0] d; logic [7:0] i; int k;
            k = $urandom_range(0, 9);
            d = 8'h07;
            case (k)
                0: i = 8'h30;
                1: i = 8'hE0; 2: i = 8'hE1; 3: i = 8'hE2;
                4: i = 8'hE4; 5: i = 8'hE5; 6: i = 8'hE6;
                7: begin d = 8'h0F; i = 8'hE0; end
                8: begin d = 8'h0F; i = 8'hE1; end
                default: begin d = 8'($urandom); i = 8'($urandom); end
            endcase
            do_wr(d, i, 8'($urandom));
            pins_chk("R5 R6 random drive");
            pin_in = 16'($urandom);
            k = $urandom_range(0, 9);
            case (k)
                0: rd_chk(8'h07, 8'h30, "R2 random enable");
                1: rd_chk(8'h07, 8'hE1, "R7 random data0");
                2: rd_chk(8'h07, 8'hE5, "R7 random data1");
                3: rd_chk(8'h07, 8'hE4, "R3 random dir1");
                4: rd_chk(8'h07, 8'hE6, "R3 random inv1");
                5: rd_chk(8'h0F, 8'hE0, "R3 random mode0");
                6: rd_chk(8'h07, 8'hE0, "R3 random dir0");
                default: rd_chk(8'($urandom), 8'($urandom), "R3 random any");
            endcase
        end

        summary();
    end
endmodule